// File: doc/BRIEF.md
# Frame Header Decode and Fetch Sequencer

This block runs once per displayed frame, between the display register unit and a frame DMA engine. When a frame starts it reads the depth field of the first palette word from the start of the current frame buffer. It turns that field into a pixel depth and a header length, checks that the programmed frame fits inside the buffer, and then issues one fetch request for the pixel data. The request carries the start address after the header, the line step in bytes and the total byte length. One buffer, or two buffers used in turn, are supported. Each accepted frame is reported to the DMA side through sticky condition bits and an interrupt pulse.

The register unit drives the configuration inputs as levels and pulses `en_wr` to change the enable state. The memory side answers a single header read with the 3-bit depth field. The fetch engine accepts the pixel request with `fetch_ack`.

Top module: `fhdr_seq`

## Requirements
- R1: After reset `enabled`, `busy`, `rd_req`, `fetch_req`, `sync_err`, `frame_done`, `dma_irq`, `buf_sel` and `cond` are all 0.
- R2: An enable write (`en_wr`=1, `en_val`=1) while disabled checks buffer 0 top and bottom, and also buffer 1 top and bottom when `dual`=1, against the window WIN_LO..WIN_HI inclusive. If all are inside, `enabled` goes to 1 with `buf_sel`=0 and `frame_done`=0. Otherwise `enabled` stays 0, `cond[2]` is set, and `dma_irq` pulses for one cycle if `irq_en[1]`=1.
- R3: The depth field `rd_code` maps code 1 to 2 bpp, 2 to 4 bpp, 3 to 8 bpp and 4 to 7 to 16 bpp. `fetch_c12`=1 only for 16 bpp with `tft`=0.
- R4: The header length is 0x200 bytes for codes 3 to 7 and 0x20 bytes for codes 1 and 2. In `mode`=2 no header read is made (`rd_req` stays 0), the header length is 0, and the most recently read code is used.
- R5: Code 0 skips the frame. There is no fetch, `cond` is unchanged, no interrupt is raised and the sequencer returns to idle.
- R6: A frame with top + header + width×height×bpp/8 > bottom + 2 sets `sync_err`, clears `enabled` and issues no fetch. A frame whose sum equals bottom + 2 is accepted.
- R7: An accepted frame sets `cond[buf_sel]` and pulses `dma_irq` for one cycle if `irq_en[0]`=1.
- R8: With `dual`=1, `buf_sel` toggles after each accepted frame and the next frame uses the other buffer. With `dual`=0 it stays 0.
- R9: Without a subpanel, `fetch_addr` = top + header, `fetch_step` = width×bpp/8 (rounded down) and `fetch_len` = step × height.
- R10: With `sub_on`=1 and `sub_first`=1, `sub_val` is the first displayed line. `fetch_addr` moves by `sub_val`×step and the line count is height − `sub_val`, or 0 when `sub_val` ≥ height.
- R11: With `sub_on`=1 and `sub_first`=0, the line count is the smaller of `sub_val` and height, and the address is not moved.
- R12: A disable write while enabled clears `enabled`, `sync_err` and `buf_sel`. It sets `frame_done` unless `mode`=1, in which case `frame_done` is cleared.
- R13: `frm_start` is ignored while disabled, while busy, or in `mode`=1. No read and no fetch follow it.
- R14: `cond_clr` clears all condition bits. A frame accepted in the same cycle keeps its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Load mode: 1 no display, 2 no header, others header read |
| tft | input | 1 | Active-matrix panel; selects full 16-bit colour |
| dual | input | 1 | Two buffers used in turn |
| width | input | DIM_W | Pixels per line |
| height | input | DIM_W | Lines per frame |
| sub_on | input | 1 | Subpanel restriction active |
| sub_first | input | 1 | 1: sub_val is first line; 0: sub_val is line count |
| sub_val | input | DIM_W | Subpanel line value |
| irq_en | input | 2 | Bit 0 frame interrupt, bit 1 address error interrupt |
| buf0_top | input | AW | Buffer 0 start address |
| buf0_bot | input | AW | Buffer 0 end address |
| buf1_top | input | AW | Buffer 1 start address |
| buf1_bot | input | AW | Buffer 1 end address |
| en_wr | input | 1 | Enable write strobe |
| en_val | input | 1 | Enable value written |
| frm_start | input | 1 | Frame start pulse |
| cond_clr | input | 1 | Clear condition bits |
| rd_req | output | 1 | Header read request |
| rd_addr | output | AW | Header read address |
| rd_ack | input | 1 | Header read response valid |
| rd_code | input | 3 | Depth field of the first palette word |
| fetch_req | output | 1 | Pixel fetch request |
| fetch_addr | output | AW | Pixel data start address |
| fetch_step | output | DIM_W+2 | Bytes per line |
| fetch_len | output | 2*DIM_W+2 | Total bytes to fetch |
| fetch_bpp | output | 5 | Bits per pixel |
| fetch_c12 | output | 1 | 12-bit colour format |
| fetch_ack | input | 1 | Fetch request accepted |
| enabled | output | 1 | Controller enabled |
| busy | output | 1 | Frame sequence in progress |
| buf_sel | output | 1 | Current buffer index |
| sync_err | output | 1 | Frame overflowed its buffer |
| frame_done | output | 1 | Done flag set on disable |
| cond | output | 3 | Bits 1:0 buffer frame accepted, bit 2 address error |
| dma_irq | output | 1 | One-cycle DMA interrupt pulse |

## Verification
The bench sweeps every depth code against several widths, heights, panel types and load modes. A wrong decode table, or a header length swapped between the short and long groups, shows up as a shifted address or the wrong step. The buffer-fit test places the bottom address exactly on the limit and one byte below it, so an off-by-one in the two-byte slack either rejects a legal frame or accepts an overflowing one. Subpanel values at 0, inside the frame, at the height and past it catch a line count that underflows or is not clipped. The dual-buffer and enable-check cases catch a buffer 1 address checked in single mode, a missing toggle, and a condition bit set for the wrong buffer.

// File: rtl/fhdr_pkg.sv
// Shared types and constants for the frame header sequencer.
package fhdr_pkg;

    // Sequencer states: idle, header read, decode/check, fetch handoff
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD    = 2'd1,
        ST_CHK   = 2'd2,
        ST_FETCH = 2'd3
    } seq_st_t;

    localparam logic [1:0] MODE_NODISP = 2'd1;
    localparam logic [1:0] MODE_NOHDR  = 2'd2;

    localparam logic [9:0] HDR_LONG  = 10'h200;
    localparam logic [9:0] HDR_SHORT = 10'h020;

endpackage

// File: rtl/fhdr_decode.sv
// Depth decoder: turns the 3-bit depth field into bits per pixel, colour
// format and header length. Assumes the code is stable during the check cycle.
module fhdr_decode
    import fhdr_pkg::*;
(
    input  logic [2:0] code,
    input  logic       tft,
    input  logic       no_hdr,
    output logic       depth_ok,
    output logic [4:0] bpp,
    output logic       c12,
    output logic [9:0] hdr_off
);

    // Map depth code to bpp; header length follows the long/short grouping
    always_comb begin
        depth_ok = 1'b1;
        c12      = 1'b0;
        case (code)
            3'd1:    bpp = 5'd2;
            3'd2:    bpp = 5'd4;
            3'd3:    bpp = 5'd8;
            3'd0: begin
                bpp      = 5'd0;
                depth_ok = 1'b0;
            end
            default: begin
                bpp = 5'd16;
                c12 = !tft;
            end
        endcase
        if (no_hdr)
            hdr_off = 10'd0;
        else if (code >= 3'd3)
            hdr_off = HDR_LONG;
        else
            hdr_off = HDR_SHORT;
    end

endmodule

// File: rtl/fhdr_geom.sv
// Frame geometry: computes byte size, buffer fit, line step, displayed line
// window and fetch address/length. Pure combinational; assumes bpp <= 16.
module fhdr_geom #(
    parameter int DIM_W = 10,
    parameter int AW    = 24
) (
    input  logic [4:0]           bpp,
    input  logic [9:0]           hdr_off,
    input  logic [DIM_W-1:0]     width,
    input  logic [DIM_W-1:0]     height,
    input  logic                 sub_on,
    input  logic                 sub_first,
    input  logic [DIM_W-1:0]     sub_val,
    input  logic [AW-1:0]        top,
    input  logic [AW-1:0]        bot,
    output logic                 fits,
    output logic [AW-1:0]        f_addr,
    output logic [DIM_W+1:0]     f_step,
    output logic [2*DIM_W+1:0]   f_len
);

    localparam int PW     = 2 * DIM_W;
    localparam int BW     = PW + 5;
    localparam int LW     = DIM_W + 5;
    localparam int STEP_W = DIM_W + 2;
    localparam int LEN_W  = PW + 2;
    localparam int CW     = ((AW > BW) ? AW : BW) + 2;

    logic [PW-1:0]    pix;
    logic [BW-1:0]    frame_bits;
    logic [BW-1:0]    frame_bytes;
    logic [LW-1:0]    line_bits;
    logic [DIM_W-1:0] first;
    logic [DIM_W-1:0] lines;
    logic [CW-1:0]    end_c;
    logic [CW-1:0]    lim_c;

    // Frame size in bytes and line step from pixel counts and depth
    always_comb begin
        pix         = PW'(width) * PW'(height);
        frame_bits  = BW'(pix) * BW'(bpp);
        frame_bytes = frame_bits >> 3;
        line_bits   = LW'(width) * LW'(bpp);
        f_step      = STEP_W'(line_bits >> 3);
    end

    // Displayed line window from the subpanel selection
    always_comb begin
        first = '0;
        lines = height;
        if (sub_on && sub_first) begin
            first = sub_val;
            lines = (sub_val < height) ? (height - sub_val) : '0;
        end else if (sub_on) begin
            lines = (sub_val < height) ? sub_val : height;
        end
    end

    // Buffer fit check (two bytes of slack) and fetch outputs
    always_comb begin
        end_c  = CW'(top) + CW'(hdr_off) + CW'(frame_bytes);
        lim_c  = CW'(bot) + CW'(2);
        fits   = (end_c <= lim_c);
        f_addr = AW'(CW'(top) + CW'(hdr_off) + CW'(first) * CW'(f_step));
        f_len  = LEN_W'(f_step) * LEN_W'(lines);
    end

endmodule

// File: rtl/fhdr_addr_chk.sv
// Address window checker: every address whose use bit is set must lie in
// LO..HI inclusive. Addresses arrive packed, lowest index in the low bits.
module fhdr_addr_chk #(
    parameter int           AW = 24,
    parameter int           N  = 4,
    parameter logic [AW-1:0] LO = '0,
    parameter logic [AW-1:0] HI = '1
) (
    input  logic [N*AW-1:0] addrs,
    input  logic [N-1:0]    use_mask,
    output logic            all_ok
);

    logic [N-1:0] ok;

    for (genvar i = 0; i < N; i++) begin : g_win
        logic [AW-1:0] a;
        // Per-address window compare
        always_comb begin
            a     = addrs[i*AW +: AW];
            ok[i] = !use_mask[i] || ((a >= LO) && (a <= HI));
        end
    end

    assign all_ok = &ok;

endmodule

// File: rtl/fhdr_seq.sv
// Frame header decode and fetch sequencer (top). Per frame: read the depth
// field from the current buffer, decode, check fit, then hand one fetch to the
// DMA. Assumes configuration inputs are stable while busy and rd_ack/fetch_ack
// answer requests that stay asserted until acknowledged.
module fhdr_seq
    import fhdr_pkg::*;
#(
    parameter int            AW     = 24,
    parameter int            DIM_W  = 10,
    parameter logic [AW-1:0] WIN_LO = 24'h001000,
    parameter logic [AW-1:0] WIN_HI = 24'hEFFFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 tft,
    input  logic                 dual,
    input  logic [DIM_W-1:0]     width,
    input  logic [DIM_W-1:0]     height,
    input  logic                 sub_on,
    input  logic                 sub_first,
    input  logic [DIM_W-1:0]     sub_val,
    input  logic [1:0]           irq_en,
    input  logic [AW-1:0]        buf0_top,
    input  logic [AW-1:0]        buf0_bot,
    input  logic [AW-1:0]        buf1_top,
    input  logic [AW-1:0]        buf1_bot,
    input  logic                 en_wr,
    input  logic                 en_val,
    input  logic                 frm_start,
    input  logic                 cond_clr,
    output logic                 rd_req,
    output logic [AW-1:0]        rd_addr,
    input  logic                 rd_ack,
    input  logic [2:0]           rd_code,
    output logic                 fetch_req,
    output logic [AW-1:0]        fetch_addr,
    output logic [DIM_W+1:0]     fetch_step,
    output logic [2*DIM_W+1:0]   fetch_len,
    output logic [4:0]           fetch_bpp,
    output logic                 fetch_c12,
    input  logic                 fetch_ack,
    output logic                 enabled,
    output logic                 busy,
    output logic                 buf_sel,
    output logic                 sync_err,
    output logic                 frame_done,
    output logic [2:0]           cond,
    output logic                 dma_irq
);

    localparam int NBUF_ADDR = 4;

    seq_st_t               st_q;
    logic [2:0]            code_q;
    logic                  en_q, sel_q, sync_q, fdone_q, irq_q;
    logic [2:0]            cond_q;
    logic [AW-1:0]         f_addr_q;
    logic [DIM_W+1:0]      f_step_q;
    logic [2*DIM_W+1:0]    f_len_q;
    logic [4:0]            f_bpp_q;
    logic                  f_c12_q;

    logic [AW-1:0]         cur_top, cur_bot;
    logic                  depth_ok, c12, fits, addr_ok;
    logic [4:0]            bpp;
    logic [9:0]            hdr_off;
    logic [AW-1:0]         g_addr;
    logic [DIM_W+1:0]      g_step;
    logic [2*DIM_W+1:0]    g_len;
    logic                  do_en, do_dis;

    // Current buffer bounds from the buffer index
    always_comb begin
        cur_top = sel_q ? buf1_top : buf0_top;
        cur_bot = sel_q ? buf1_bot : buf0_bot;
    end

    fhdr_decode u_dec (
        .code     (code_q),
        .tft      (tft),
        .no_hdr   (mode == MODE_NOHDR),
        .depth_ok (depth_ok),
        .bpp      (bpp),
        .c12      (c12),
        .hdr_off  (hdr_off)
    );

    fhdr_geom #(.DIM_W(DIM_W), .AW(AW)) u_geom (
        .bpp       (bpp),
        .hdr_off   (hdr_off),
        .width     (width),
        .height    (height),
        .sub_on    (sub_on),
        .sub_first (sub_first),
        .sub_val   (sub_val),
        .top       (cur_top),
        .bot       (cur_bot),
        .fits      (fits),
        .f_addr    (g_addr),
        .f_step    (g_step),
        .f_len     (g_len)
    );

    fhdr_addr_chk #(.AW(AW), .N(NBUF_ADDR), .LO(WIN_LO), .HI(WIN_HI)) u_achk (
        .addrs    ({buf1_bot, buf1_top, buf0_bot, buf0_top}),
        .use_mask ({dual, dual, 2'b11}),
        .all_ok   (addr_ok)
    );

    assign do_en  = en_wr && en_val && !en_q;
    assign do_dis = en_wr && !en_val && en_q;

    // Sequencer, enable control and DMA-side status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            code_q   <= '0;
            en_q     <= 1'b0;
            sel_q    <= 1'b0;
            sync_q   <= 1'b0;
            fdone_q  <= 1'b0;
            irq_q    <= 1'b0;
            cond_q   <= '0;
            f_addr_q <= '0;
            f_step_q <= '0;
            f_len_q  <= '0;
            f_bpp_q  <= '0;
            f_c12_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (cond_clr)
                cond_q <= '0;
            if (do_en) begin
                if (addr_ok) begin
                    en_q    <= 1'b1;
                    sel_q   <= 1'b0;
                    fdone_q <= 1'b0;
                    st_q    <= ST_IDLE;
                end else begin
                    cond_q[2] <= 1'b1;
                    irq_q     <= irq_en[1];
                end
            end else if (do_dis) begin
                en_q    <= 1'b0;
                sel_q   <= 1'b0;
                sync_q  <= 1'b0;
                fdone_q <= (mode != MODE_NODISP);
                st_q    <= ST_IDLE;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        if (frm_start && en_q && (mode != MODE_NODISP))
                            st_q <= (mode == MODE_NOHDR) ? ST_CHK : ST_RD;
                    end
                    ST_RD: begin
                        if (rd_ack) begin
                            code_q <= rd_code;
                            st_q   <= ST_CHK;
                        end
                    end
                    ST_CHK: begin
                        if (!depth_ok) begin
                            st_q <= ST_IDLE;
                        end else if (!fits) begin
                            sync_q <= 1'b1;
                            en_q   <= 1'b0;
                            st_q   <= ST_IDLE;
                        end else begin
                            cond_q[sel_q] <= 1'b1;
                            irq_q         <= irq_en[0];
                            if (dual)
                                sel_q <= !sel_q;
                            f_addr_q <= g_addr;
                            f_step_q <= g_step;
                            f_len_q  <= g_len;
                            f_bpp_q  <= bpp;
                            f_c12_q  <= c12;
                            st_q     <= ST_FETCH;
                        end
                    end
                    default: begin
                        if (fetch_ack)
                            st_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign rd_req     = (st_q == ST_RD);
    assign rd_addr    = cur_top;
    assign fetch_req  = (st_q == ST_FETCH);
    assign fetch_addr = f_addr_q;
    assign fetch_step = f_step_q;
    assign fetch_len  = f_len_q;
    assign fetch_bpp  = f_bpp_q;
    assign fetch_c12  = f_c12_q;
    assign enabled    = en_q;
    assign busy       = (st_q != ST_IDLE);
    assign buf_sel    = sel_q;
    assign sync_err   = sync_q;
    assign frame_done = fdone_q;
    assign cond       = cond_q;
    assign dma_irq    = irq_q;

    // R13
    rd_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> enabled);

    // R7
    fetch_sets_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> (cond[1:0] != 2'b00));

    // R6
    sync_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> !enabled);

    // R9
    fetch_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (!fetch_req || $stable(fetch_addr)));

    // R12
    done_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> !enabled);

endmodule

// File: tb/fhdr_seq_tb.sv
module fhdr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 10;

    logic clk = 0, rst_n = 0;
    logic [1:0] mode = 0, irq_en = 0;
    logic tft = 0, dual = 0, sub_on = 0, sub_first = 0;
    logic [DW-1:0] width = 8, height = 2, sub_val = 0;
    logic [AW-1:0] b0t = 24'h002000, b0b = 24'h012000, b1t = 24'h040000, b1b = 24'h050000;
    logic en_wr = 0, en_val = 0, frm_start = 0, cond_clr = 0;
    logic rd_req, fetch_req, enabled, busy, buf_sel, sync_err, frame_done, dma_irq, fetch_c12;
    logic [AW-1:0] rd_addr, fetch_addr;
    logic [DW+1:0] fetch_step;
    logic [2*DW+1:0] fetch_len;
    logic [4:0] fetch_bpp;
    logic [2:0] cond, rd_code = 0;

    int n_run = 0, n_fail = 0;
    bit saw_rd, saw_fetch;
    int irq_cnt, en_irq;
    longint c_addr, c_step, c_len, c_bpp, c_c12;

    always #(CLK_PERIOD/2) clk = ~clk;

    fhdr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tft(tft), .dual(dual),
        .width(width), .height(height), .sub_on(sub_on), .sub_first(sub_first),
        .sub_val(sub_val), .irq_en(irq_en), .buf0_top(b0t), .buf0_bot(b0b),
        .buf1_top(b1t), .buf1_bot(b1b), .en_wr(en_wr), .en_val(en_val),
        .frm_start(frm_start), .cond_clr(cond_clr), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(1'b1), .rd_code(rd_code), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_step(fetch_step), .fetch_len(fetch_len),
        .fetch_bpp(fetch_bpp), .fetch_c12(fetch_c12), .fetch_ack(1'b1),
        .enabled(enabled), .busy(busy), .buf_sel(buf_sel), .sync_err(sync_err),
        .frame_done(frame_done), .cond(cond), .dma_irq(dma_irq)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ebpp(input int c);
        if (c == 0) return 0;
        if (c == 1) return 2;
        if (c == 2) return 4;
        if (c == 3) return 8;
        return 16;
    endfunction

    function automatic int eoff(input int c, input int m);
        if (m == 2) return 0;
        return (c >= 3) ? 'h200 : 'h20;
    endfunction

    task automatic do_en(input bit v);
        @(negedge clk); en_wr = 1; en_val = v;
        @(negedge clk); en_wr = 0; en_irq = dma_irq;
    endtask

    task automatic clr_cond();
        @(negedge clk); cond_clr = 1;
        @(negedge clk); cond_clr = 0;
    endtask

    task automatic run_frame();
        saw_rd = 0; saw_fetch = 0; irq_cnt = 0;
        @(negedge clk); frm_start = 1;
        @(negedge clk); frm_start = 0;
        for (int i = 0; i < 12; i++) begin
            if (rd_req) saw_rd = 1;
            if (dma_irq) irq_cnt++;
            if (fetch_req) begin
                saw_fetch = 1;
                c_addr = fetch_addr; c_step = fetch_step; c_len = fetch_len;
                c_bpp = fetch_bpp; c_c12 = fetch_c12;
            end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 enabled", enabled, 0); chk("R1 busy", busy, 0);
        chk("R1 cond", cond, 0); chk("R1 flags", {sync_err, frame_done, dma_irq, buf_sel, rd_req, fetch_req}, 0);

        // R13 start while disabled is ignored
        run_frame();
        chk("R13 disabled no read", saw_rd, 0);
        chk("R13 disabled no fetch", saw_fetch, 0);

        // R2 window check: buffer 1 bottom outside window, dual on
        irq_en = 2'b10; dual = 1; b1b = 24'hF00000;
        do_en(1);
        chk("R2 bad dual enabled", enabled, 0);
        chk("R2 bad cond2", cond[2], 1);
        chk("R2 bad irq", en_irq, 1);
        clr_cond();
        chk("R14 cond cleared", cond, 0);
        // R2 buffer 0 top below window, single
        dual = 0; b0t = 24'h000800;
        do_en(1);
        chk("R2 bad top enabled", enabled, 0);
        chk("R2 bad top cond2", cond[2], 1);
        b0t = 24'h002000;
        clr_cond();
        // R2 single mode ignores buffer 1
        irq_en = 2'b00;
        do_en(1);
        chk("R2 good enabled", enabled, 1);
        chk("R2 good no irq", en_irq, 0);
        chk("R2 buf_sel", buf_sel, 0);
        b1b = 24'h050000;

        // R3 R4 R5 R7 R9 sweep
        irq_en = 2'b01;
        for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < 2; t++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int wi = 0; wi < 3; wi++) begin
                        for (int h = 2; h < 4; h++) begin
                            int w, bp, st;
                            w = (wi == 0) ? 4 : (wi == 1) ? 5 : 8;
                            mode = (m == 0) ? 2'd0 : 2'd3; tft = t[0];
                            width = DW'(w); height = DW'(h); rd_code = 3'(c);
                            clr_cond();
                            run_frame();
                            bp = ebpp(c); st = (w * bp) / 8;
                            chk("R4 header read", saw_rd, 1);
                            if (c == 0) begin
                                chk("R5 skip no fetch", saw_fetch, 0);
                                chk("R5 skip cond", cond, 0);
                                chk("R5 skip irq", irq_cnt, 0);
                            end else begin
                                chk("R7 fetch", saw_fetch, 1);
                                chk("R3 bpp", c_bpp, bp);
                                chk("R3 c12", c_c12, (bp == 16 && t == 0) ? 1 : 0);
                                chk("R4 R9 addr", c_addr, b0t + eoff(c, 0));
                                chk("R9 step", c_step, st);
                                chk("R9 len", c_len, st * h);
                                chk("R7 cond", cond, 1);
                                chk("R7 irq", irq_cnt, 1);
                                chk("R8 single sel", buf_sel, 0);
                            end
                        end
                    end
                end
            end
        end

        // R4 mode 2: no read, offset 0, last code (7) reused
        mode = 2; rd_code = 3'd1; tft = 1; width = 8; height = 2;
        run_frame();
        chk("R4 nohdr no read", saw_rd, 0);
        chk("R4 nohdr addr", c_addr, b0t);
        chk("R4 nohdr bpp", c_bpp, 16);

        // R7 irq disabled
        mode = 0; irq_en = 0; rd_code = 3'd3;
        run_frame();
        chk("R7 no irq when masked", irq_cnt, 0);

        // R10 first-line subpanel, 8bpp, width 8, height 6
        width = 8; height = 6; sub_on = 1; sub_first = 1;
        for (int k = 0; k < 5; k++) begin
            int v;
            v = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 5 : (k == 3) ? 6 : 9;
            sub_val = DW'(v);
            run_frame();
            chk("R10 addr", c_addr, b0t + 'h200 + v * 8);
            chk("R10 len", c_len, 8 * ((v < 6) ? 6 - v : 0));
        end
        // R11 line-count subpanel
        sub_first = 0;
        for (int k = 0; k < 4; k++) begin
            int v;
            v = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 6 : 10;
            sub_val = DW'(v);
            run_frame();
            chk("R11 addr", c_addr, b0t + 'h200);
            chk("R11 len", c_len, 8 * ((v < 6) ? v : 6));
        end
        sub_on = 0;

        // R6 boundary: 16bpp w8 h4 -> 64 bytes + 0x200 header
        rd_code = 3'd4; width = 8; height = 4;
        b0b = b0t + 'h200 + 64 - 2;
        run_frame();
        chk("R6 exact fit fetch", saw_fetch, 1);
        chk("R6 exact fit sync", sync_err, 0);
        b0b = b0b - 1;
        run_frame();
        chk("R6 overflow no fetch", saw_fetch, 0);
        chk("R6 overflow sync", sync_err, 1);
        chk("R6 overflow disabled", enabled, 0);
        b0b = 24'h012000;

        // R12 disable in mode 0 clears sync and sets done
        do_en(1);
        chk("R12 re-enable", enabled, 1);
        do_en(0);
        chk("R12 disabled", enabled, 0);
        chk("R12 sync cleared", sync_err, 0);
        chk("R12 done mode0", frame_done, 1);
        // R12 mode 1 disable leaves done clear; R13 start ignored in mode 1
        mode = 1;
        do_en(1);
        chk("R12 done cleared on enable", frame_done, 0);
        run_frame();
        chk("R13 mode1 no read", saw_rd, 0);
        chk("R13 mode1 no fetch", saw_fetch, 0);
        do_en(0);
        chk("R12 done mode1", frame_done, 0);

        // R8 dual alternation, R14 set wins only for own bit
        mode = 0; dual = 1; irq_en = 1; rd_code = 3'd3; width = 8; height = 2;
        do_en(1);
        clr_cond();
        run_frame();
        chk("R8 first addr", c_addr, b0t + 'h200);
        chk("R8 sel after first", buf_sel, 1);
        chk("R8 cond first", cond, 3'b001);
        run_frame();
        chk("R8 second addr", c_addr, b1t + 'h200);
        chk("R8 sel after second", buf_sel, 0);
        chk("R8 cond second", cond, 3'b011);
        do_en(0);
        chk("R12 sel reset", buf_sel, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule